// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes an SDRAM device from power-up to normal operation. On a start request it captures a 32-bit timing configuration word and a 32-bit bank configuration word. From them it derives the mode-register data (CAS latency, clock-speed class, data-bus width), unless a preset value is supplied. It then drives a controller timing word whose command field walks through the standard bring-up list of precharge, refresh and mode-register-set.

A pass has three steps. First the block applies an initialization word with auto-refresh disabled and waits out the power-up delay. Then it issues twenty commands, each held for a fixed gap. Finally it restores the normal running word. The whole pass runs twice back to back. A one-cycle done pulse follows, and the running word, with refresh enabled, stays on the output.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is held and after it, until a start is accepted, `timing_out` is 0 (enable bit 31 clear, command NOP), and `busy` and `done` are 0.
- R2: If bits 23:16 of the timing configuration are nonzero, those bits are used as the mode data unchanged.
- R3: Otherwise the CAS field is bits 1:0 of the timing configuration. With bit 12 set, the value 0 means CAS 2; with bit 12 clear, the value 1 means CAS 2; any other value means CAS 3. The mode data is 0x40, with 0x20 added for CAS 3.
- R4: Bit 23 of the bank configuration selects the bus width: 1 is 32-bit and 0 is 16-bit. For a 16-bit bus the derived mode data is shifted right by one, giving 0x20 or 0x30.
- R5: The running word is (timing & 0x8000F9FF) | 0x80000000. The initialization word is the running word with bits 15:14 set and the mode data placed in bits 23:16.
- R6: For WAIT cycles after the start is accepted (WAIT = CLK_KHZ*WAIT_US/1000), the output is the initialization word with command field bits 10:9 equal to 0 (NOP).
- R7: The command field at bits 10:9 is then driven with 3 = precharge-all, 0 = NOP, 2 = auto-refresh and 1 = mode-register set. The order is precharge, NOP, eight pairs of (refresh, NOP), mode-register set, NOP: 20 commands.
- R8: Each command stays on the output for GAP_CYCLES+1 consecutive cycles.
- R9: After the last command, the running word is output for one cycle. The complete pass, including the wait, is then repeated once.
- R10: `busy` is high from the cycle after start is accepted through the last restore cycle. `done` pulses for exactly that final cycle. Afterwards the running word remains on `timing_out`.
- R11: Start is ignored while busy, and configuration inputs changed after acceptance have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch request, accepted when idle |
| timing_cfg | input | 32 | Timing configuration word |
| bank_cfg | input | 32 | Bank configuration word (bit 23 = bus width) |
| timing_out | output | 32 | Timing word driven to the memory controller |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse at the end of the second pass |

## Verification
A new start request can coincide with the final restore cycle, the same cycle in which `done` pulses. The bench raises start with a different configuration exactly in that cycle. It expects the request to be dropped: the next cycle must show `busy` low and the running word from the first configuration. A further start pulse in the middle of a pass, with the configuration inputs inverted, must leave the cycle-by-cycle output identical to the model computed from the originally captured words.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    typedef enum logic [1:0] {
        CMD_NOP  = 2'd0,
        CMD_MRS  = 2'd1,
        CMD_REF  = 2'd2,
        CMD_PALL = 2'd3
    } sdcmd_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_CMDS,
        ST_RESTORE
    } seq_state_e;

    typedef struct packed {
        logic [31:0] run_word;
        logic [31:0] init_word;
    } word_pair_t;

    localparam int          SEQ_LEN   = 20;
    localparam int          CMD_LSB   = 9;
    localparam int          MODE_LSB  = 16;
    localparam int          SPEED_BIT = 12;
    localparam int          WIDTH_BIT = 23;
    localparam logic [31:0] KEEP_MASK = 32'h8000_F9FF;
    localparam logic [31:0] EN_BIT    = 32'h8000_0000;
    localparam logic [31:0] REF_OFF   = 32'h0000_C000;

    function automatic sdcmd_e cmd_at(logic [4:0] idx);
        if (idx == 5'd0)
            return CMD_PALL;
        else if (idx == 5'(SEQ_LEN - 2))
            return CMD_MRS;
        else if (idx[0])
            return CMD_NOP;
        else
            return CMD_REF;
    endfunction

    function automatic logic [31:0] make_run(logic [31:0] t);
        return (t & KEEP_MASK) | EN_BIT;
    endfunction

endpackage

// File: rtl/sdram_mode_calc.sv
module sdram_mode_calc
    import sdram_init_pkg::*;
(
    input  logic [31:0] timing,
    input  logic [31:0] bank,
    output logic [7:0]  mode
);
    logic [7:0] preset;
    logic       cas3;
    logic [7:0] derived;

    always_comb begin
        preset = timing[23:16];
        if (timing[SPEED_BIT])
            cas3 = (timing[1:0] != 2'd0);
        else
            cas3 = (timing[1:0] != 2'd1);
        derived = 8'h40 | (cas3 ? 8'h20 : 8'h00);
        if (!bank[WIDTH_BIT])
            derived = derived >> 1;
        mode = (preset != 8'h00) ? preset : derived;
    end
endmodule

// File: rtl/sdram_delay_timer.sv
module sdram_delay_timer #(
    parameter int LIMIT = 20000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/sdram_cmd_stepper.sv
module sdram_cmd_stepper
    import sdram_init_pkg::*;
#(
    parameter int LEN  = 20,
    parameter int SLOT = 6
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   run,
    output sdcmd_e cmd,
    output logic   last
);
    localparam int SW = $clog2(SLOT + 1);

    logic [4:0]    idx;
    logic [SW-1:0] sub;
    logic          slot_end;

    assign slot_end = (sub == SW'(SLOT - 1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            idx <= '0;
            sub <= '0;
        end else if (slot_end) begin
            sub <= '0;
            idx <= idx + 5'd1;
        end else begin
            sub <= sub + 1'b1;
        end
    end

    assign cmd  = cmd_at(idx);
    assign last = run && slot_end && (idx == 5'(LEN - 1));
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int CLK_KHZ    = 100000,
    parameter int WAIT_US    = 200,
    parameter int GAP_CYCLES = 5
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [31:0] timing_cfg,
    input  logic [31:0] bank_cfg,
    output logic [31:0] timing_out,
    output logic        busy,
    output logic        done
);
    localparam int WAIT_CYCLES = (CLK_KHZ * WAIT_US) / 1000;
    localparam int SLOT        = GAP_CYCLES + 1;

    seq_state_e state;
    logic       second_pass;
    logic       finished;
    word_pair_t words;
    logic [7:0] mode_data;
    logic       wait_done;
    logic       cmds_done;
    sdcmd_e     cur_cmd;

    sdram_mode_calc u_mode (
        .timing (timing_cfg),
        .bank   (bank_cfg),
        .mode   (mode_data)
    );

    sdram_delay_timer #(.LIMIT(WAIT_CYCLES)) u_delay (
        .clk     (clk),
        .rst     (rst),
        .run     (state == ST_WAIT),
        .expired (wait_done)
    );

    sdram_cmd_stepper #(.LEN(SEQ_LEN), .SLOT(SLOT)) u_step (
        .clk  (clk),
        .rst  (rst),
        .run  (state == ST_CMDS),
        .cmd  (cur_cmd),
        .last (cmds_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            second_pass <= 1'b0;
            finished    <= 1'b0;
            words       <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state            <= ST_WAIT;
                    second_pass      <= 1'b0;
                    words.run_word   <= make_run(timing_cfg);
                    words.init_word  <= make_run(timing_cfg) | REF_OFF
                                        | (32'(mode_data) << MODE_LSB);
                end
                ST_WAIT: if (wait_done) state <= ST_CMDS;
                ST_CMDS: if (cmds_done) state <= ST_RESTORE;
                ST_RESTORE: begin
                    if (second_pass) begin
                        state    <= ST_IDLE;
                        finished <= 1'b1;
                    end else begin
                        state       <= ST_WAIT;
                        second_pass <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        case (state)
            ST_WAIT:    timing_out = words.init_word;
            ST_CMDS:    timing_out = words.init_word | (32'(cur_cmd) << CMD_LSB);
            ST_RESTORE: timing_out = words.run_word;
            default:    timing_out = finished ? words.run_word : 32'h0;
        endcase
    end

    assign busy = (state != ST_IDLE);
    assign done = (state == ST_RESTORE) && second_pass;
endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic [31:0] timing_out,
    input logic        busy,
    input logic        done
);
    p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_in_busy_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    p_launch_r10: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> busy);

    p_busy_holds_r11: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);

    p_idle_nop_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (timing_out[10:9] == 2'b00));

    p_enable_set_r5: assert property (@(posedge clk) disable iff (rst)
        busy |-> timing_out[31]);

    p_low_bits_stable_r11: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(timing_out[8:0]));

    p_refresh_off_cmd_r7: assert property (@(posedge clk) disable iff (rst)
        (timing_out[10:9] != 2'b00) |-> (timing_out[15:14] == 2'b11));
endmodule

bind sdram_init_seq sdram_init_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .timing_out (timing_out),
    .busy       (busy),
    .done       (done)
);

// File: tb/sim_sdram_init_seq.sv
`timescale 1ns/1ps
module sim_sdram_init_seq;
    localparam int KHZ  = 200;
    localparam int W    = KHZ * 200 / 1000;
    localparam int GAP  = 5;
    localparam int S    = GAP + 1;
    localparam int P    = W + 20 * S + 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] timing_cfg = '0;
    logic [31:0] bank_cfg = '0;
    logic [31:0] timing_out;
    logic        busy;
    logic        done;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    sdram_init_seq #(.CLK_KHZ(KHZ), .WAIT_US(200), .GAP_CYCLES(GAP)) u0 (
        .clk(clk), .rst(rst), .start(start), .timing_cfg(timing_cfg),
        .bank_cfg(bank_cfg), .timing_out(timing_out), .busy(busy), .done(done)
    );

    function automatic logic [7:0] exp_mode(logic [31:0] t, logic [31:0] b);
        logic c2;
        logic [7:0] m;
        if (t[23:16] != 0) return t[23:16];
        c2 = t[12] ? (t[1:0] == 2'd0) : (t[1:0] == 2'd1);
        m = c2 ? 8'h40 : 8'h60;
        if (!b[23]) m = m >> 1;
        return m;
    endfunction

    function automatic logic [31:0] exp_run(logic [31:0] t);
        return (t & 32'h8000_F9FF) | 32'h8000_0000;
    endfunction

    function automatic logic [1:0] exp_cmd(int i);
        if (i == 0) return 2'd3;
        if (i == 18) return 2'd1;
        if (i % 2 == 1) return 2'd0;
        return 2'd2;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one full launch, compared every cycle; poke = cycle at which a stray start is raised
    task automatic run_seq(logic [31:0] t, logic [31:0] b, string tag,
                           logic [7:0] want_mode, int poke);
        logic [31:0] run_w = exp_run(t);
        logic [31:0] init_w = run_w | 32'h0000_C000 | (32'(exp_mode(t, b)) << 16);
        @(negedge clk);
        timing_cfg = t; bank_cfg = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk({tag, " mode field"}, {24'h0, timing_out[23:16]}, {24'h0, want_mode});
        for (int k = 0; k < 2 * P; k++) begin
            int j = k % P;
            logic [31:0] e;
            string ph;
            if (j < W) begin e = init_w; ph = "R6 wait word"; end
            else if (j < W + 20 * S) begin
                e = init_w | (32'(exp_cmd((j - W) / S)) << 9);
                ph = (((j - W) % S) == 0) ? "R7 command" : "R8 command hold";
            end else begin e = run_w; ph = "R9 restore"; end
            chk(ph, timing_out, e);
            chk("R10 busy", {31'h0, busy}, 32'h1);
            chk("R10 done", {31'h0, done}, {31'h0, (k == 2 * P - 1)});
            if (k == poke) begin
                start = 1'b1; timing_cfg = ~t; bank_cfg = ~b;
            end else start = 1'b0;
            @(negedge clk);
        end
        start = 1'b0;
        chk("R11 idle after done", {31'h0, busy}, 32'h0);
        chk("R10 idle word", timing_out, run_w);
        chk("R10 no done", {31'h0, done}, 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R1 reset word", timing_out, 32'h0);
        chk("R1 reset busy", {31'h0, busy}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 idle word", timing_out, 32'h0);
        chk("R1 idle done", {31'h0, done}, 32'h0);

        // directed mode cases
        run_seq(32'h0000_1000, 32'h0080_0000, "R3 fast cas2 32b", 8'h40, -1);
        run_seq(32'h0000_1002, 32'h0080_0000, "R3 fast cas3 32b", 8'h60, -1);
        run_seq(32'h0000_0003, 32'h0080_0000, "R3 slow cas3 32b", 8'h60, -1);
        run_seq(32'h0000_0001, 32'h0000_0000, "R4 slow cas2 16b", 8'h20, -1);
        run_seq(32'h0000_0000, 32'h0000_0000, "R4 slow cas3 16b", 8'h30, -1);
        run_seq(32'h005A_3FFF, 32'h0000_0000, "R2 preset", 8'h5A, -1);
        run_seq(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R5 all ones", 8'hFF, -1);
        // stray start mid-pass and in the done cycle
        run_seq(32'h1234_0001, 32'h0080_0000, "R11 mid poke", 8'h34, 50);
        run_seq(32'h0000_1001, 32'h0080_0000, "R11 done poke", 8'h60, 2 * P - 1);

        for (int n = 0; n < 12; n++) begin
            logic [31:0] t = $urandom;
            logic [31:0] b = $urandom;
            if (n % 2 == 0) t[23:16] = 8'h00;
            run_seq(t, b, "R5 random", exp_mode(t, b), (n % 3 == 0) ? 7 : -1);
        end

        // reset in the middle of a run
        @(negedge clk);
        timing_cfg = 32'h0000_1000; bank_cfg = 32'h0080_0000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (30) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R1 reset mid-run word", timing_out, 32'h0);
        chk("R1 reset mid-run busy", {31'h0, busy}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset word", timing_out, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule